// File: doc/BRIEF.md
# Speculative Register Checkpoint with Gated Store Buffer

This block holds the speculative state of a core that runs translated code blocks as atomic units. Each architectural register is kept twice. The working copy is what instructions read and write. The shadow copy holds the value from the last commit. Stores made inside a block do not go to memory. They wait in a small store buffer, and loads look in that buffer before they take memory data.

A commit pulse ends a block. It makes the working registers the new committed state, then drains the buffered stores to the memory write port, one per accepted cycle and oldest first. A rollback pulse is raised on an exception. It throws the speculative state away: every working register gets its shadow value back in one cycle, and the buffered stores are discarded without writing memory. The block can then be re-run precisely from the last committed point.

Top module: `spec_state_keeper`

## Requirements
- R1: After reset, every working and shadow register reads zero, the store buffer is empty and `mem_wr_valid` is low.
- R2: `rd_data` returns the working copy of register `rd_addr` combinationally, including a write (`wr_en`) made in an earlier cycle of the current uncommitted block.
- R3: A rollback copies every shadow register into its working register in one cycle, and a register write in the same cycle is dropped.
- R4: A commit copies every working register into its shadow copy. A register write in the commit cycle is included in the committed value.
- R5: An accepted store (`st_valid` high, `st_stall` low) causes no memory write before a commit.
- R6: Loads are forwarded from the buffer.
  - `mem_rd_addr` equals `ld_addr`.
  - For each byte k of `ld_data` (bits 8k+7:8k), the value comes from the youngest buffered store whose address equals `ld_addr` and whose byte-enable bit k is set.
  - Any byte with no such store comes from `mem_rd_data`.
- R7: A commit drains the buffered stores in program order, one per cycle in which `mem_wr_valid` and `mem_wr_ready` are both high. While `mem_wr_ready` is low, the address, data and enables stay stable.
- R8: `st_stall` equals `st_valid` when any of these holds: the buffer is full, a drain is in progress, or commit or rollback is high in that cycle. A stalled store is not buffered.
- R9: A rollback outside a drain empties the buffer and never writes memory.
- R10: When commit and rollback are high in the same cycle, rollback wins: registers are restored and no store is written.
- R11: A rollback during a drain restores the working registers, and the drain of the already committed stores still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_addr | input | RW | Register read index |
| rd_data | output | DW | Working copy of the addressed register |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | RW | Register write index |
| wr_data | input | DW | Register write value |
| st_valid | input | 1 | Store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_be | input | DW/8 | Store byte enables |
| st_stall | output | 1 | Store not accepted this cycle |
| ld_addr | input | AW | Load word address |
| ld_data | output | DW | Load result after forwarding |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DW | Memory read data |
| commit | input | 1 | End-of-block commit pulse |
| rollback | input | 1 | Exception rollback pulse |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | DW | Memory write data |
| mem_wr_be | output | DW/8 | Memory write byte enables |

## Verification
The bench stacks two stores to the same word with different byte enables and checks the load result byte by byte.
- A design that forwards whole words, or lets the older store win, returns the wrong merged word.

It fills the buffer and checks that the next store stalls. It then drains with the ready signal toggling, checking the order of the writes and the final memory contents.
- Overfilling, skipping entries or reordering them shows up in the write log.

It checks three rollback cases:
- Commit and rollback in the same cycle, where a design that lets commit win leaks the store to memory.
- A rollback during a drain, where a design that flushes the committed entries loses the write.
- A rollback after register writes, where a stale working value shows on the read port.

// File: rtl/spk_pkg.sv
// Shared types for the speculative state keeper.
// Assumes word-addressed stores with one enable bit per data byte.
package spk_pkg;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int BW = DW / 8;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [BW-1:0] be;
    } sb_entry_t;
endpackage

// File: rtl/spk_regfile.sv
// Working/shadow register pair array.
// Reads return the working copy combinationally.
// Assumes commit and rollback are single-cycle pulses; rollback has priority.
module spk_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          do_commit,
    input  logic          do_rollback
);
    logic [DW-1:0] work_q   [NREG];
    logic [DW-1:0] shadow_q [NREG];
    logic [DW-1:0] work_nx  [NREG];

    assign rd_data = work_q[rd_addr];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Next working value of one register: write applied unless rollback.
        always_comb begin
            if (do_rollback)
                work_nx[g] = shadow_q[g];
            else if (wr_en && wr_addr == RW'(g))
                work_nx[g] = wr_data;
            else
                work_nx[g] = work_q[g];
        end

        // Register update of the working and shadow copies.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                work_q[g]   <= '0;
                shadow_q[g] <= '0;
            end else begin
                work_q[g] <= work_nx[g];
                if (do_commit && !do_rollback)
                    shadow_q[g] <= work_nx[g];
            end
        end
    end
endmodule

// File: rtl/spk_store_buf.sv
// Gated store buffer with byte-wise youngest-first load forwarding and an
// in-order drain started by commit.
// Assumes DEPTH is a power of two. Entries live at indices [0, count);
// index order is program order.
module spk_store_buf
    import spk_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [BW-1:0] st_be,
    output logic          st_stall,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] mem_rd_data,
    output logic [DW-1:0] ld_data,
    input  logic          commit,
    input  logic          rollback,
    output logic          mem_wr_valid,
    input  logic          mem_wr_ready,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    output logic [BW-1:0] mem_wr_be,
    output logic [CW-1:0] count_o,
    output logic          draining_o
);
    sb_entry_t     ent_q [DEPTH];
    logic [CW-1:0] count_q;
    logic [CW-1:0] didx_q;
    logic          drain_q;
    logic          full;
    logic          accept;

    assign full     = (count_q == CW'(DEPTH));
    assign accept   = st_valid && !full && !drain_q && !commit && !rollback;
    assign st_stall = st_valid && !accept;

    assign mem_wr_valid = drain_q;
    assign mem_wr_addr  = ent_q[didx_q[IW-1:0]].addr;
    assign mem_wr_data  = ent_q[didx_q[IW-1:0]].data;
    assign mem_wr_be    = ent_q[didx_q[IW-1:0]].be;
    assign count_o      = count_q;
    assign draining_o   = drain_q;

    // Control: fill, rollback discard, commit start and drain stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            didx_q  <= '0;
            drain_q <= 1'b0;
        end else if (drain_q) begin
            if (mem_wr_ready) begin
                if (didx_q == count_q - CW'(1)) begin
                    drain_q <= 1'b0;
                    count_q <= '0;
                    didx_q  <= '0;
                end else begin
                    didx_q <= didx_q + CW'(1);
                end
            end
        end else if (rollback) begin
            count_q <= '0;
        end else if (commit) begin
            if (count_q != '0) begin
                drain_q <= 1'b1;
                didx_q  <= '0;
            end
        end else if (accept) begin
            count_q <= count_q + CW'(1);
        end
    end

    // Entry storage: capture an accepted store at the tail.
    always_ff @(posedge clk) begin
        if (accept)
            ent_q[count_q[IW-1:0]] <= '{addr: st_addr, data: st_data, be: st_be};
    end

    for (genvar b = 0; b < BW; b++) begin : g_byte
        // Per-byte forward: later (younger) matching entries override older ones.
        always_comb begin
            ld_data[8*b +: 8] = mem_rd_data[8*b +: 8];
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) < count_q && ent_q[i].addr == ld_addr && ent_q[i].be[b])
                    ld_data[8*b +: 8] = ent_q[i].data[8*b +: 8];
            end
        end
    end
endmodule

// File: rtl/spec_state_keeper.sv
// Top: speculative register checkpoint plus gated store buffer.
// Assumes commit and rollback are pulses; rollback wins when both are high.
module spec_state_keeper #(
    parameter int NREG     = 8,
    parameter int SB_DEPTH = 4,
    localparam int DW      = spk_pkg::DW,
    localparam int AW      = spk_pkg::AW,
    localparam int BW      = spk_pkg::BW,
    localparam int RW      = $clog2(NREG),
    localparam int CW      = $clog2(SB_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          st_valid,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic [BW-1:0] st_be,
    output logic          st_stall,
    input  logic [AW-1:0] ld_addr,
    output logic [DW-1:0] ld_data,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [DW-1:0] mem_rd_data,
    input  logic          commit,
    input  logic          rollback,
    output logic          mem_wr_valid,
    input  logic          mem_wr_ready,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    output logic [BW-1:0] mem_wr_be
);
    logic [CW-1:0] sb_count;
    logic          sb_draining;

    assign mem_rd_addr = ld_addr;

    spk_regfile #(.NREG(NREG), .DW(DW)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .do_commit(commit), .do_rollback(rollback)
    );

    spk_store_buf #(.DEPTH(SB_DEPTH)) sbuf_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_stall(st_stall),
        .ld_addr(ld_addr), .mem_rd_data(mem_rd_data), .ld_data(ld_data),
        .commit(commit), .rollback(rollback),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
        .count_o(sb_count), .draining_o(sb_draining)
    );
endmodule

// File: rtl/spk_checker.sv
// Property checker for spec_state_keeper, attached with bind.
module spk_checker #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_stall,
    input logic          commit,
    input logic          rollback,
    input logic          mem_wr_valid,
    input logic          mem_wr_ready,
    input logic [AW-1:0] mem_wr_addr,
    input logic [CW-1:0] sb_count,
    input logic          sb_draining
);
    // R8
    stall_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && sb_count == CW'(DEPTH)) |-> st_stall);

    // R8
    stall_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && mem_wr_valid) |-> st_stall);

    // R7
    hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr)));

    // R9
    rollback_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && !sb_draining) |=> (sb_count == '0 && !mem_wr_valid));

    // R10
    rollback_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && rollback && !sb_draining) |=> !mem_wr_valid);

    // R5
    no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wr_valid && !commit) |=> !mem_wr_valid);

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_count <= CW'(DEPTH));
endmodule

bind spec_state_keeper spk_checker #(.DEPTH(SB_DEPTH), .AW(AW), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_stall(st_stall),
    .commit(commit), .rollback(rollback), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .sb_count(sb_count), .sb_draining(sb_draining)
);

// File: tb/spec_state_keeper_tb_top.sv
module spec_state_keeper_tb_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd_addr = '0, wr_addr = '0;
    logic [31:0] rd_data, wr_data = '0;
    logic        wr_en = 1'b0;
    logic        st_valid = 1'b0;
    logic [7:0]  st_addr = '0, ld_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic        st_stall;
    logic [31:0] ld_data, mem_rd_data;
    logic [7:0]  mem_rd_addr, mem_wr_addr;
    logic        commit = 1'b0, rollback = 1'b0;
    logic        mem_wr_valid, mem_wr_ready = 1'b1;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_be;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] mem [256];
    logic [7:0]  wlog [16];
    int          wcount = 0;

    always #(PERIOD/2) clk = ~clk;

    spec_state_keeper dut_i (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_stall(st_stall), .ld_addr(ld_addr), .ld_data(ld_data),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .commit(commit), .rollback(rollback),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
    );

    assign mem_rd_data = mem[mem_rd_addr];

    // Memory model: byte-enabled write and a log of accepted addresses.
    always @(posedge clk) begin
        if (rst_n && mem_wr_valid && mem_wr_ready) begin
            for (int b = 0; b < 4; b++)
                if (mem_wr_be[b]) mem[mem_wr_addr][8*b +: 8] <= mem_wr_data[8*b +: 8];
            if (wcount < 16) wlog[wcount] <= mem_wr_addr;
            wcount <= wcount + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] e);
        rd_addr = a; #1;
        chk(req, rd_data, e);
    endtask

    task automatic store(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        cyc();
        st_valid = 1'b0;
    endtask

    task automatic pulse(input logic c, input logic r);
        commit = c; rollback = r;
        cyc();
        commit = 1'b0; rollback = 1'b0;
    endtask

    task automatic wait_drain();
        for (int k = 0; k < 100 && mem_wr_valid; k++) cyc();
    endtask

    task automatic ld_chk(input string req, input logic [7:0] a, input logic [31:0] e);
        ld_addr = a; #1;
        chk(req, ld_data, e);
    endtask

    // Register vectors: {kind, index, value}; kind 0 write, 1 read-check,
    // 2 commit, 3 rollback, 4 commit+rollback.
    localparam int NV = 14;
    localparam logic [43:0] VEC [NV] = '{
        {4'd0, 8'd1, 32'h0000_0011},
        {4'd1, 8'd1, 32'h0000_0011},   // R2
        {4'd0, 8'd2, 32'h0000_0022},
        {4'd2, 8'd0, 32'h0},           // R4
        {4'd0, 8'd1, 32'h0000_0033},
        {4'd1, 8'd1, 32'h0000_0033},   // R2
        {4'd3, 8'd0, 32'h0},           // R3
        {4'd1, 8'd1, 32'h0000_0011},   // R3
        {4'd1, 8'd2, 32'h0000_0022},   // R4
        {4'd0, 8'd2, 32'h0000_0055},
        {4'd4, 8'd0, 32'h0},           // R10
        {4'd1, 8'd2, 32'h0000_0022},   // R10
        {4'd0, 8'd3, 32'h0000_0044},
        {4'd1, 8'd3, 32'h0000_0044}
    };

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h1000_0000 + i;
        mem[8'h10] = 32'h5566_7788;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();

        // R1: reset state
        rd_chk("R1 reg", 3'd1, 32'h0);
        chk("R1 wr_valid", {31'b0, mem_wr_valid}, 32'h0);
        ld_chk("R1 empty buffer", 8'h10, 32'h5566_7788);

        for (int v = 0; v < NV; v++) begin
            case (VEC[v][43:40])
                4'd0: reg_wr(VEC[v][34:32], VEC[v][31:0]);
                4'd1: rd_chk("R2/R3/R4/R10 vector read", VEC[v][34:32], VEC[v][31:0]);
                4'd2: pulse(1'b1, 1'b0);
                4'd3: pulse(1'b0, 1'b1);
                default: pulse(1'b1, 1'b1);
            endcase
        end

        // R4: write in the commit cycle is committed
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'hCAFE; commit = 1'b1;
        cyc();
        wr_en = 1'b0; commit = 1'b0;
        reg_wr(3'd4, 32'hBEEF);
        pulse(1'b0, 1'b1);
        rd_chk("R4 same-cycle commit write", 3'd4, 32'hCAFE);

        // R6 / R5: forwarding with byte merge
        store(8'h10, 32'hAABB_CCDD, 4'hF);
        store(8'h10, 32'h1122_3344, 4'h3);
        ld_chk("R6 byte merge youngest", 8'h10, 32'hAABB_3344);
        ld_chk("R6 miss to memory", 8'h20, 32'h1000_0020);
        chk("R6 read addr", {24'b0, mem_rd_addr}, 32'h20);
        chk("R5 no write before commit", wcount, 0);

        // R8: fill and stall
        store(8'h20, 32'h0000_2020, 4'hF);
        store(8'h30, 32'h0000_3030, 4'hC);
        st_valid = 1'b1; st_addr = 8'h70; st_data = 32'h7; st_be = 4'hF; #1;
        chk("R8 stall when full", {31'b0, st_stall}, 32'h1);
        cyc();
        st_valid = 1'b0;
        ld_chk("R8 stalled store dropped", 8'h70, 32'h1000_0070);

        // R7: drain with ready toggling
        mem_wr_ready = 1'b0;
        pulse(1'b1, 1'b0);
        st_valid = 1'b1; st_addr = 8'h71; #1;
        chk("R8 stall during drain", {31'b0, st_stall}, 32'h1);
        cyc(); cyc();
        st_valid = 1'b0;
        chk("R7 held while not ready", wcount, 0);
        for (int k = 0; k < 12 && mem_wr_valid; k++) begin
            mem_wr_ready = k[0];
            cyc();
        end
        mem_wr_ready = 1'b1;
        wait_drain();
        chk("R7 write count", wcount, 4);
        chk("R7 order 0", {24'b0, wlog[0]}, 32'h10);
        chk("R7 order 1", {24'b0, wlog[1]}, 32'h10);
        chk("R7 order 2", {24'b0, wlog[2]}, 32'h20);
        chk("R7 order 3", {24'b0, wlog[3]}, 32'h30);
        chk("R7 merged memory", mem[8'h10], 32'hAABB_3344);
        chk("R7 byte-enabled memory", mem[8'h30], 32'h0000_0030);

        // R9: rollback discards stores
        store(8'h40, 32'hDEAD_0040, 4'hF);
        pulse(1'b0, 1'b1);
        cyc(); cyc();
        chk("R9 no write on rollback", wcount, 4);
        ld_chk("R9 buffer empty", 8'h40, 32'h1000_0040);

        // R10: commit and rollback together
        store(8'h50, 32'hDEAD_0050, 4'hF);
        pulse(1'b1, 1'b1);
        cyc(); cyc();
        chk("R10 store not released", wcount, 4);
        ld_chk("R10 store discarded", 8'h50, 32'h1000_0050);

        // R11: rollback during drain
        store(8'h60, 32'h0000_6060, 4'hF);
        reg_wr(3'd5, 32'h7);
        mem_wr_ready = 1'b0;
        pulse(1'b1, 1'b0);
        reg_wr(3'd5, 32'h9);
        pulse(1'b0, 1'b1);
        rd_chk("R11 regs restored", 3'd5, 32'h7);
        mem_wr_ready = 1'b1;
        wait_drain();
        chk("R11 drain completes", mem[8'h60], 32'h0000_6060);
        chk("R11 write count", wcount, 5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule